// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers up to 31 external interrupt lines and presents them to two processor contexts. Source IDs run from 1 to 31. ID 0 is reserved and means "nothing to take". Each source has a 3-bit priority. A gateway in front of each source treats it as either a level-high input or a rising-edge input; the parameter `EDGE_SRC` selects which, one bit per ID. Each context has its own enable mask, its own 3-bit threshold and its own claim/complete register. Each context also has one registered interrupt request line.

Software works through a small synchronous bus with address, write data, write strobe, read strobe and read data. The register map is sparse and fixed. A handler reads its context's claim register to get the ID of the best eligible source, and that read also claims the source. The handler writes the same ID back to finish service. A source is eligible only when it is pending, enabled for the context, and its priority is strictly above the context's threshold.

Top module: `plic_core`

## Requirements
- R1: After reset, every request output is low, and all priority, enable and threshold registers read 0. A claim read returns 0.
- R2: The priority of source N is the word at byte address 4*N. It is 3 bits wide and bits 31:3 read 0. The word at address 0 (ID 0) reads 0 and ignores writes.
- R3: The enable mask of context c is the word at 0x2000 + 0x80*c. Bit N enables source N for that context only. Bit 0 and every other word in that block read 0.
- R4: Context c has its threshold word at 0x200000 + 0x1000*c and its claim/complete word at that address + 4. The threshold is 3 bits wide.
- R5: A source reaches a context only when it is pending, enabled there, and its priority is strictly greater than that context's threshold. A threshold of 7 blocks every source, and a priority of 0 never fires.
- R6: Among eligible sources, the highest priority wins. On equal priority, the lowest ID wins.
- R7: Read data appears on the cycle after the read strobe. A claim read returns the winning ID and clears that source's pending bit in the same operation. It returns 0 when nothing is eligible.
- R8: Writing a claimed ID to a claim/complete word ends service for that source. Writing an ID that is not in service (0, unclaimed, or out of range) has no effect.
- R9: A level source is not made pending again while in service. After completion it becomes pending again if its line is still high.
- R10: An edge source (`EDGE_SRC` bit N set) becomes pending on a rising edge. Of the rising edges that arrive while it is in service, exactly one is kept, and it is delivered after completion.
- R11: A context's request output is a register. It goes high one cycle after the state first gives a nonzero claim result, and it goes low one cycle after that result returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NSRC (31) | Source lines, bit N is source ID N |
| bus_addr_i | input | AW (24) | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe, also triggers a claim |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| ctx_irq_o | output | NCTX (2) | Request line per context |

## Verification
A corrupted pending or in-service bit appears at the ports in one of three ways. A claim read may return a source that should be masked, a source may be delivered twice, or a source may never come back after completion. A bad selection shows as a wrong ID on the very next claim read. The request line lags the internal state by exactly one cycle, so a wrong threshold or enable value shows on that line within two cycles of the write. An edge latch that is lost or duplicated shows only after completion, so the bench claims, completes and claims again around each edge burst.

// File: rtl/plic_core.sv
module plic_core #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int AW   = 24,
  parameter logic [31:0] EDGE_SRC = 32'hFF00_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC:1]   irq_src_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  input  logic            bus_we_i,
  input  logic            bus_re_i,
  output logic [31:0]     bus_rdata_o,
  output logic [NCTX-1:0] ctx_irq_o
);
  localparam int IW = $clog2(NSRC + 1);
  localparam int PGW = AW - 12;
  localparam int CTX_PAGE = 'h200;

  logic [NSRC:1][PW-1:0]   prio;
  logic [NCTX-1:0][NSRC:1] en;
  logic [NCTX-1:0][PW-1:0] thr;
  logic [NSRC:1] pend, busy, lat, prev, take, done;
  logic [NCTX-1:0][IW-1:0] best_id;
  logic [NCTX-1:0][PW-1:0] best_p;
  logic [NCTX-1:0] hit_thr, hit_clm;
  logic [31:0] rd_val;

  wire [PGW-1:0] page = bus_addr_i[AW-1:12];
  wire [11:0]    off  = bus_addr_i[11:0];
  wire is_prio = (page == '0);
  wire is_en   = (page == PGW'(2)) && (off[6:2] == 5'd0);

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      hit_thr[c] = (page == PGW'(CTX_PAGE + c)) && (off == 12'h000);
      hit_clm[c] = (page == PGW'(CTX_PAGE + c)) && (off == 12'h004);
    end
  end

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      best_id[c] = '0;
      best_p[c]  = thr[c];
      for (int i = 1; i <= NSRC; i++)
        if (pend[i] && en[c][i] && prio[i] > best_p[c]) begin
          best_id[c] = IW'(i);
          best_p[c]  = prio[i];
        end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 1; i <= NSRC; i++)
      if (is_prio && off[11:2] == 10'(i)) rd_val = 32'(prio[i]);
    for (int c = 0; c < NCTX; c++) begin
      if (is_en && off[11:7] == 5'(c)) rd_val = 32'({en[c], 1'b0});
      if (hit_thr[c]) rd_val = 32'(thr[c]);
      if (hit_clm[c]) rd_val = 32'(best_id[c]);
    end
  end

  always_comb begin
    take = '0;
    done = '0;
    for (int c = 0; c < NCTX; c++)
      for (int i = 1; i <= NSRC; i++) begin
        if (bus_re_i && hit_clm[c] && best_id[c] == IW'(i)) take[i] = 1'b1;
        if (bus_we_i && hit_clm[c] && bus_wdata_i == 32'(i) && busy[i]) done[i] = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; busy <= '0; lat <= '0; prev <= '0;
    end else begin
      prev <= irq_src_i;
      for (int i = 1; i <= NSRC; i++) begin
        if (EDGE_SRC[i]) begin
          if (take[i]) begin
            pend[i] <= 1'b0; busy[i] <= 1'b1;
            lat[i]  <= irq_src_i[i] & ~prev[i];
          end else if (done[i]) begin
            busy[i] <= 1'b0;
            pend[i] <= lat[i] | (irq_src_i[i] & ~prev[i]);
            lat[i]  <= 1'b0;
          end else if (irq_src_i[i] && !prev[i]) begin
            if (busy[i]) lat[i] <= 1'b1;
            else pend[i] <= 1'b1;
          end
        end else begin
          if (take[i]) begin
            pend[i] <= 1'b0; busy[i] <= 1'b1;
          end else if (done[i]) busy[i] <= 1'b0;
          else if (!busy[i] && irq_src_i[i]) pend[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio <= '0; en <= '0; thr <= '0;
      bus_rdata_o <= '0; ctx_irq_o <= '0;
    end else begin
      if (bus_re_i) bus_rdata_o <= rd_val;
      for (int i = 1; i <= NSRC; i++)
        if (bus_we_i && is_prio && off[11:2] == 10'(i)) prio[i] <= bus_wdata_i[PW-1:0];
      for (int c = 0; c < NCTX; c++) begin
        if (bus_we_i && is_en && off[11:7] == 5'(c)) en[c] <= bus_wdata_i[NSRC:1];
        if (bus_we_i && hit_thr[c]) thr[c] <= bus_wdata_i[PW-1:0];
        ctx_irq_o[c] <= (best_id[c] != '0);
      end
    end
  end
endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int AW   = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [AW-1:0]           bus_addr_i,
  input logic                    bus_re_i,
  input logic [31:0]             bus_rdata_o,
  input logic [NCTX-1:0]         ctx_irq_o,
  input logic [NSRC:1]           pend,
  input logic [NSRC:1]           busy,
  input logic [NCTX-1:0][PW-1:0] thr
);
  localparam int IW = $clog2(NSRC + 1);
  wire [AW-13:0] pg = bus_addr_i[AW-1:12];
  wire claim_hit = (pg >= (AW-12)'('h200)) && (pg < (AW-12)'('h200 + NCTX)) &&
                   (bus_addr_i[11:0] == 12'h004);

  p_pend_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & busy) == '0);

  p_claim_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re_i && claim_hit |=> bus_rdata_o <= 32'(NSRC));

  p_claim_marks_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re_i && claim_hit |=> (bus_rdata_o == 0) || busy[bus_rdata_o[IW-1:0]]);

  p_prio_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re_i && pg == '0 |=> bus_rdata_o[31:PW] == '0);

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    p_thr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      thr[c] == {PW{1'b1}} |=> !ctx_irq_o[c]);
  end
endmodule

bind plic_core plic_core_chk #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_re_i(bus_re_i),
  .bus_rdata_o(bus_rdata_o), .ctx_irq_o(ctx_irq_o), .pend(pend), .busy(busy), .thr(thr)
);

// File: tb/plic_core_tb.sv
module plic_core_tb;
  logic clk = 0, rst_n = 0;
  logic [31:1] src = '0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  logic we = 0, re = 0;
  logic [1:0] irq;
  int nchk = 0, nerr = 0;
  logic [2:0] mprio [1:31];

  always #2.5 clk = ~clk;

  plic_core u_dut (.clk(clk), .rst_n(rst_n), .irq_src_i(src), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata), .ctx_irq_o(irq));

  function automatic [23:0] a_prio(int id); return 24'(4 * id); endfunction
  function automatic [23:0] a_en(int c); return 24'('h2000 + 'h80 * c); endfunction
  function automatic [23:0] a_thr(int c); return 24'('h200000 + 'h1000 * c); endfunction
  function automatic [23:0] a_clm(int c); return 24'('h200004 + 'h1000 * c); endfunction

  function automatic int best(logic [31:1] p, logic [31:1] e, logic [2:0] t);
    int id = 0;
    logic [2:0] bp = t;
    for (int i = 1; i <= 31; i++)
      if (p[i] && e[i] && mprio[i] > bp) begin id = i; bp = mprio[i]; end
    return id;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [23:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1;
    @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  initial begin
    #2_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(a_prio(5), v); chk("R1 prio", v, 0);
    rd(a_en(0), v); chk("R1 en", v, 0);
    rd(a_thr(1), v); chk("R1 thr", v, 0);
    rd(a_clm(0), v); chk("R1 claim", v, 0);
    // R2 priority width and ID 0
    wr(a_prio(5), 32'hFF); rd(a_prio(5), v); chk("R2 width", v, 7);
    wr(a_prio(0), 7); rd(a_prio(0), v); chk("R2 id0", v, 0);
    wr(a_prio(5), 0);
    // R3 enable layout
    wr(a_en(0), 32'hFFFF_FFFF); rd(a_en(0), v); chk("R3 bit0", v, 32'hFFFF_FFFE);
    rd(a_en(1), v); chk("R3 ctx1 separate", v, 0);
    rd(a_en(0) + 4, v); chk("R3 word1", v, 0);
    // R4/R5 threshold strictness
    wr(a_thr(0), 32'h1A); rd(a_thr(0), v); chk("R4 thr width", v, 2);
    wr(a_prio(3), 2); src[3] = 1; settle();
    chk("R5 equal blocked", 32'(irq[0]), 0);
    rd(a_clm(0), v); chk("R5 equal claim", v, 0);
    wr(a_thr(0), 1); settle(); chk("R11 irq up", 32'(irq[0]), 1);
    wr(a_prio(3), 7); wr(a_thr(0), 7); settle(); chk("R5 thr7", 32'(irq[0]), 0);
    wr(a_thr(0), 0); wr(a_prio(3), 0); settle(); chk("R5 prio0", 32'(irq[0]), 0);
    rd(a_clm(0), v); chk("R5 prio0 claim", v, 0);
    // R6 ordering
    wr(a_prio(3), 2); wr(a_prio(4), 5); wr(a_prio(9), 5); wr(a_thr(0), 1);
    src[4] = 1; src[9] = 1; settle();
    rd(a_clm(0), v); chk("R6 tie low id", v, 4);
    rd(a_clm(0), v); chk("R6 second", v, 9);
    rd(a_clm(0), v); chk("R6 lower prio", v, 3);
    rd(a_clm(0), v); chk("R7 empty", v, 0);
    settle(); chk("R9 no repend in service", 32'(irq[0]), 0);
    // R8 ignored completions
    wr(a_clm(0), 0); wr(a_clm(0), 7); wr(a_clm(0), 32); settle();
    chk("R8 ignored irq", 32'(irq[0]), 0);
    rd(a_clm(0), v); chk("R8 ignored claim", v, 0);
    // R9 level re-pend after completion
    wr(a_clm(0), 9); settle(); chk("R11 irq after complete", 32'(irq[0]), 1);
    rd(a_clm(0), v); chk("R9 repend", v, 9);
    src[3] = 0; src[4] = 0; src[9] = 0;
    wr(a_clm(0), 3); wr(a_clm(1), 4); wr(a_clm(0), 9); settle();
    rd(a_clm(0), v); chk("R9 low line stays idle", v, 0);
    // R10 edge source
    wr(a_prio(25), 3);
    src[25] = 1; @(negedge clk); src[25] = 0; settle();
    chk("R10 edge irq", 32'(irq[0]), 1);
    rd(a_clm(0), v); chk("R10 edge claim", v, 25);
    for (int k = 0; k < 2; k++) begin
      src[25] = 1; @(negedge clk); src[25] = 0; @(negedge clk);
    end
    settle(); rd(a_clm(0), v); chk("R10 held in service", v, 0);
    wr(a_clm(0), 25); settle();
    rd(a_clm(0), v); chk("R10 latched edge", v, 25);
    wr(a_clm(0), 25); settle();
    rd(a_clm(0), v); chk("R10 only one latched", v, 0);
    // R3 per-context routing
    wr(a_en(0), 0); wr(a_en(1), 32'h80); wr(a_prio(7), 4); src[7] = 1; settle();
    chk("R3 ctx0 quiet", 32'(irq[0]), 0);
    chk("R3 ctx1 up", 32'(irq[1]), 1);
    rd(a_clm(0), v); chk("R3 ctx0 claim", v, 0);
    rd(a_clm(1), v); chk("R3 ctx1 claim", v, 7);
    src[7] = 0; wr(a_clm(1), 7); wr(a_en(1), 0);
    // random rounds on level sources 1..23
    for (int i = 1; i <= 31; i++) mprio[i] = 0;
    mprio[25] = 3;
    for (int r = 0; r < 30; r++) begin
      logic [31:1] pm, em, sm;
      logic [2:0] tm;
      logic [31:0] seed;
      int claimed [$];
      int e;
      seed = $urandom(r + 7);
      tm = 3'($urandom % 8);
      em = 31'($urandom) & 31'h7F_FFFF;
      sm = 31'($urandom) & 31'h7F_FFFF;
      for (int i = 1; i <= 23; i++) begin
        mprio[i] = 3'($urandom % 8);
        wr(a_prio(i), 32'(mprio[i]));
      end
      wr(a_thr(0), 32'(tm)); wr(a_en(0), {em, 1'b0});
      src = sm; settle();
      pm = sm;
      e = best(pm, em, tm);
      chk("R11 random irq", 32'(irq[0]), 32'(e != 0));
      for (int k = 0; k < 24; k++) begin
        e = best(pm, em, tm);
        rd(a_clm(0), v); chk("R6 random claim", v, 32'(e));
        if (e == 0) break;
        pm[e] = 0; claimed.push_back(e);
      end
      src = '0;
      foreach (claimed[j]) wr(a_clm(0), 32'(claimed[j]));
      wr(a_thr(0), 0); wr(a_en(0), 32'hFFFF_FFFE);
      for (int i = 1; i <= 23; i++) begin mprio[i] = 1; wr(a_prio(i), 1); end
      for (int k = 0; k < 24; k++) begin
        rd(a_clm(0), v);
        if (v == 0) break;
        wr(a_clm(0), v);
      end
      rd(a_clm(0), v); chk("R7 drained", v, 0);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule